// File: doc/BRIEF.md
# ADC Result Window Detector

This block watches the stream of conversion results from an ADC and raises a sticky window interrupt flag when a result lands in a programmed zone. Two 16-bit limits are held in the block: a greater-than limit and a less-than limit. The relative size of the two limits sets the polarity of the zone. When the less-than limit is the larger one, the block looks for results strictly between the limits (inside detection). Otherwise, which includes equal limits, it looks for results strictly above the greater-than limit or strictly below the less-than limit (outside detection). All comparisons are unsigned.

Results arrive with a one-cycle valid strobe. The block can sum a batch of 1, 4, 8 or 16 results before it compares, so that software reacts only to an averaged level. The sum is compared once the batch is complete, and the running sum then starts again from zero. A right-justified 10-bit sample simply occupies the low bits of the 16-bit compare value. Software programs the limits and the batch size through a small write-only register port, and clears the flag with a clear strobe.

Top module: `adc_window_det`

## Requirements
- R1: After reset win_flag and cmp_done are 0, the greater-than limit is 0xFFFF, the less-than limit is 0 and the batch size is 1, so that no result of any value raises a match.
- R2: When the less-than limit is greater than the greater-than limit, cmp_match is 1 only for gt < value < lt. A value equal to either limit, or outside them, gives 0.
- R3: When the greater-than limit is greater than the less-than limit, cmp_match is 1 only for value > gt or value < lt. Values from lt to gt inclusive give 0.
- R4: With both limits equal to L, outside detection applies: every value except L matches.
- R5: The batch-size field takes 0, 1, 2 or 3 for 1, 4, 8 or 16 samples. cmp_done pulses only on the last sample of a batch. cmp_value is then the sum of the batch modulo 2^16.
- R6: After each compare the running sum restarts from zero, so the next batch sums only its own samples.
- R7: A write to the batch-size register throws away any partial sum. A sample presented in the same cycle as that write is also dropped.
- R8: win_flag stays at 1 until flag_clr is pulsed. A clear in a cycle with no match returns it to 0.
- R9: When flag_clr and cmp_match are both high in the same cycle, win_flag is 1 afterwards.
- R10: Register map on reg_addr when reg_wr is high: address 0 sets the greater-than limit, address 1 sets the less-than limit, and address 2 sets the batch size from reg_wdata[1:0]. A write to address 3 changes nothing.
- R11: cmp_done, cmp_value and cmp_match are valid in the cycle after the clock edge that takes the last sample of a batch. win_flag rises at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Result strobe, one cycle per ADC result |
| smp_data | input | 16 | ADC result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| flag_clr | input | 1 | Software clear of the window flag |
| win_flag | output | 1 | Sticky window interrupt flag |
| cmp_done | output | 1 | A compare happens this cycle |
| cmp_value | output | 16 | Value under compare (sample or batch sum) |
| cmp_match | output | 1 | The value under compare meets the window |

## Verification
The two functions that can fall in the same cycle are the software clear of the flag and the hardware setting of the flag by a new match. The bench first leaves the flag set by an earlier match. It then completes a matching batch and holds flag_clr high in the very cycle where cmp_match is high. It passes only if the flag reads 1 after that edge. A separate case pulses the clear with no match pending and expects 0, so a design that lets the clear always win fails the first case, and a design whose clear does nothing fails the second.

// File: rtl/adc_window_pkg.sv
package adc_window_pkg;

    localparam int unsigned WIN_W      = 16;
    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned ACC_MAX    = 16;
    localparam int unsigned ACC_CNT_W  = $clog2(ACC_MAX);

    typedef logic [WIN_W-1:0] win_word_t;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_GT_LIM  = 2'd0,
        REG_LT_LIM  = 2'd1,
        REG_ACC_SEL = 2'd2,
        REG_SPARE   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACC_X1  = 2'd0,
        ACC_X4  = 2'd1,
        ACC_X8  = 2'd2,
        ACC_X16 = 2'd3
    } acc_sel_e;

    typedef enum logic {
        MODE_OUTSIDE = 1'b0,
        MODE_INSIDE  = 1'b1
    } win_mode_e;

    typedef struct packed {
        win_word_t gt;
        win_word_t lt;
    } lim_pair_t;

    typedef struct packed {
        logic      done;
        win_word_t value;
    } cmp_beat_t;

    // Index of the last sample of a batch for a given size selection.
    function automatic logic [ACC_CNT_W-1:0] acc_last(acc_sel_e sel);
        case (sel)
            ACC_X1:  return ACC_CNT_W'(0);
            ACC_X4:  return ACC_CNT_W'(3);
            ACC_X8:  return ACC_CNT_W'(7);
            default: return ACC_CNT_W'(ACC_MAX - 1);
        endcase
    endfunction

    // Polarity follows the order of the limits; ties go to outside mode.
    function automatic win_mode_e mode_of(lim_pair_t lim);
        return (lim.lt > lim.gt) ? MODE_INSIDE : MODE_OUTSIDE;
    endfunction

endpackage

// File: rtl/adc_window_regs.sv
module adc_window_regs
    import adc_window_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  win_word_t             wdata,
    output lim_pair_t             lims,
    output acc_sel_e              acc_sel,
    output logic                  acc_restart
);

    reg_addr_e sel_addr;
    assign sel_addr = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            lims.gt <= '1;
            lims.lt <= '0;
            acc_sel <= ACC_X1;
        end else if (wr) begin
            case (sel_addr)
                REG_GT_LIM:  lims.gt <= wdata;
                REG_LT_LIM:  lims.lt <= wdata;
                REG_ACC_SEL: acc_sel <= acc_sel_e'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    assign acc_restart = wr && (sel_addr == REG_ACC_SEL);

endmodule

// File: rtl/adc_window_accum.sv
module adc_window_accum
    import adc_window_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_valid,
    input  win_word_t smp_data,
    input  acc_sel_e  acc_sel,
    input  logic      restart,
    output cmp_beat_t beat
);

    win_word_t              sum_q;
    logic [ACC_CNT_W-1:0]   cnt_q;
    win_word_t              total;
    logic                   last;

    assign total = sum_q + smp_data;
    assign last  = (cnt_q == acc_last(acc_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q      <= '0;
            cnt_q      <= '0;
            beat.done  <= 1'b0;
            beat.value <= '0;
        end else begin
            beat.done <= 1'b0;
            if (restart) begin
                sum_q <= '0;
                cnt_q <= '0;
            end else if (smp_valid) begin
                if (last) begin
                    beat.done  <= 1'b1;
                    beat.value <= total;
                    sum_q      <= '0;
                    cnt_q      <= '0;
                end else begin
                    sum_q <= total;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
    import adc_window_pkg::*;
(
    input  lim_pair_t lims,
    input  cmp_beat_t beat,
    output win_mode_e mode,
    output logic      match
);

    logic above_gt;
    logic below_lt;
    logic hit;

    assign mode     = mode_of(lims);
    assign above_gt = beat.value > lims.gt;
    assign below_lt = beat.value < lims.lt;

    always_comb begin
        case (mode)
            MODE_INSIDE: hit = above_gt && below_lt;
            default:     hit = above_gt || below_lt;
        endcase
    end

    assign match = beat.done && hit;

endmodule

// File: rtl/adc_window_flag.sv
module adc_window_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/adc_window_det.sv
module adc_window_det
    import adc_window_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic [WIN_W-1:0]      smp_data,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WIN_W-1:0]      reg_wdata,
    input  logic                  flag_clr,
    output logic                  win_flag,
    output logic                  cmp_done,
    output logic [WIN_W-1:0]      cmp_value,
    output logic                  cmp_match
);

    lim_pair_t lims;
    acc_sel_e  acc_sel;
    logic      acc_restart;
    cmp_beat_t beat;
    win_mode_e mode;
    win_word_t gt_lim;
    win_word_t lt_lim;

    adc_window_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .lims        (lims),
        .acc_sel     (acc_sel),
        .acc_restart (acc_restart)
    );

    adc_window_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .acc_sel   (acc_sel),
        .restart   (acc_restart),
        .beat      (beat)
    );

    adc_window_cmp u_cmp (
        .lims  (lims),
        .beat  (beat),
        .mode  (mode),
        .match (cmp_match)
    );

    adc_window_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (cmp_match),
        .clr  (flag_clr),
        .flag (win_flag)
    );

    assign cmp_done  = beat.done;
    assign cmp_value = beat.value;
    assign gt_lim    = lims.gt;
    assign lt_lim    = lims.lt;

endmodule

// File: rtl/adc_window_det_chk.sv
module adc_window_det_chk
    import adc_window_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      flag_clr,
    input logic      win_flag,
    input logic      cmp_done,
    input logic      cmp_match,
    input win_word_t cmp_value,
    input win_word_t gt_lim,
    input win_word_t lt_lim
);

    AST_MATCH_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> cmp_done); // R5

    AST_INSIDE_STRICT: assert property (@(posedge clk) disable iff (rst)
        (cmp_match && (lt_lim > gt_lim)) |-> (cmp_value > gt_lim && cmp_value < lt_lim)); // R2

    AST_LIMIT_EQUAL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && (cmp_value == gt_lim || cmp_value == lt_lim) && !(cmp_value > gt_lim || cmp_value < lt_lim))
        |-> !cmp_match); // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (win_flag && !flag_clr) |=> win_flag); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cmp_match) |=> !win_flag); // R8

    AST_MATCH_WINS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> win_flag); // R9

    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(win_flag) |-> $past(cmp_match)); // R11

endmodule

bind adc_window_det adc_window_det_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flag_clr  (flag_clr),
    .win_flag  (win_flag),
    .cmp_done  (cmp_done),
    .cmp_match (cmp_match),
    .cmp_value (cmp_value),
    .gt_lim    (gt_lim),
    .lt_lim    (lt_lim)
);

// File: tb/adc_window_det_bench.sv
module adc_window_det_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        win_flag;
    logic        cmp_done;
    logic [15:0] cmp_value;
    logic        cmp_match;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    adc_window_det u_adc_window_det (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag_clr  (flag_clr),
        .win_flag  (win_flag),
        .cmp_done  (cmp_done),
        .cmp_value (cmp_value),
        .cmp_match (cmp_match)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Returns at the negedge after the capture edge: compare outputs are live.
    task automatic push(input logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Single-sample compare with flag timing and cleanup.
    task automatic one(input string req, input logic [15:0] d, input logic exp);
        push(d);
        chk(req, "cmp_done", cmp_done, 1);
        chk(req, "cmp_value", cmp_value, d);
        chk(req, "cmp_match", cmp_match, exp);
        chk("R11", "flag not yet set", win_flag, 0);
        @(negedge clk);
        chk(req, "win_flag", win_flag, exp);
        clear_flag();
        chk("R8", "flag cleared", win_flag, 0);
    endtask

    task automatic t_reset();
        chk("R1", "win_flag after reset", win_flag, 0);
        chk("R1", "cmp_done after reset", cmp_done, 0);
        one("R1", 16'h0000, 1'b0);
        one("R1", 16'hFFFF, 1'b0);
        one("R1", 16'h8000, 1'b0);
    endtask

    task automatic t_inside();
        wr_reg(2'd0, 16'd100);
        wr_reg(2'd1, 16'd200);
        one("R2", 16'd150, 1'b1);
        one("R2", 16'd101, 1'b1);
        one("R2", 16'd199, 1'b1);
        one("R2", 16'd100, 1'b0);
        one("R2", 16'd200, 1'b0);
        one("R2", 16'd50,  1'b0);
        one("R2", 16'd250, 1'b0);
    endtask

    task automatic t_outside();
        wr_reg(2'd0, 16'd200);
        wr_reg(2'd1, 16'd100);
        one("R3", 16'd250, 1'b1);
        one("R3", 16'd50,  1'b1);
        one("R3", 16'd150, 1'b0);
        one("R3", 16'd200, 1'b0);
        one("R3", 16'd100, 1'b0);
    endtask

    task automatic t_equal();
        wr_reg(2'd0, 16'd300);
        wr_reg(2'd1, 16'd300);
        one("R4", 16'd300, 1'b0);
        one("R4", 16'd301, 1'b1);
        one("R4", 16'd299, 1'b1);
    endtask

    task automatic t_accum();
        wr_reg(2'd0, 16'd90);
        wr_reg(2'd1, 16'd0);
        wr_reg(2'd2, 16'd1);
        push(16'd10); chk("R5", "x4 no compare s1", cmp_done, 0);
        push(16'd20); chk("R5", "x4 no compare s2", cmp_done, 0);
        push(16'd30); chk("R5", "x4 no compare s3", cmp_done, 0);
        push(16'd40);
        chk("R5", "x4 done", cmp_done, 1);
        chk("R5", "x4 sum", cmp_value, 100);
        chk("R5", "x4 match", cmp_match, 1);
        @(negedge clk);
        chk("R11", "flag after batch", win_flag, 1);
        clear_flag();
        // R6: next batch starts from zero
        for (int i = 0; i < 4; i++) push(16'd1);
        chk("R6", "fresh batch sum", cmp_value, 4);
        chk("R6", "fresh batch no match", cmp_match, 0);
        wr_reg(2'd2, 16'd2);
        for (int i = 0; i < 7; i++) begin
            push(16'd3);
            chk("R5", "x8 early", cmp_done, 0);
        end
        push(16'd3);
        chk("R5", "x8 sum", cmp_value, 24);
        wr_reg(2'd2, 16'd3);
        for (int i = 0; i < 15; i++) push(16'h1000);
        chk("R5", "x16 early", cmp_done, 0);
        push(16'h1000);
        chk("R5", "x16 done", cmp_done, 1);
        chk("R5", "x16 sum wraps", cmp_value, 0);
        @(negedge clk);
        clear_flag();
    endtask

    task automatic t_restart();
        wr_reg(2'd2, 16'd1);
        push(16'd5);
        push(16'd5);
        wr_reg(2'd2, 16'd1);   // R7: partial sum discarded
        for (int i = 0; i < 3; i++) push(16'd1);
        chk("R7", "no early compare", cmp_done, 0);
        push(16'd1);
        chk("R7", "sum after restart", cmp_value, 4);
        wr_reg(2'd2, 16'd0);
        clear_flag();
    endtask

    task automatic t_sticky_and_race();
        wr_reg(2'd0, 16'd100);
        wr_reg(2'd1, 16'd200);
        push(16'd150);
        @(negedge clk);
        chk("R8", "flag set", win_flag, 1);
        push(16'd10);
        chk("R8", "non-match compare", cmp_match, 0);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8", "flag sticky", win_flag, 1);
        // R9: clear in the very cycle of a new match
        push(16'd160);
        chk("R9", "match present", cmp_match, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R9", "match beats clear", win_flag, 1);
        clear_flag();
        chk("R8", "clear alone", win_flag, 0);
    endtask

    task automatic t_spare_addr();
        wr_reg(2'd0, 16'd100);
        wr_reg(2'd1, 16'd200);
        wr_reg(2'd3, 16'd0);
        one("R10", 16'd150, 1'b1);
        wr_reg(2'd3, 16'hFFFF);
        one("R10", 16'd50, 1'b0);
        // single-sample mode still active after spare write
        one("R10", 16'd199, 1'b1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inside();
        t_outside();
        t_equal();
        t_accum();
        t_restart();
        t_sticky_and_race();
        t_spare_addr();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule